// File: doc/BRIEF.md
# Two-Sample IF Field Vector Detector

This block takes a stream of signed ADC samples of an intermediate-frequency sinusoid and turns every pair of consecutive samples into the in-phase and quadrature components of the field vector. The sample clock and the IF are locked together, and the phase advance between samples is not a quarter period. So I and Q are not picked out by sign patterns. Each pair is instead combined with four trigonometric weights, and these weights change from one sample slot to the next. The default ratio is three samples for every two IF periods, which is a phase advance of 240 degrees. With that ratio the weight set repeats every three accepted samples.

The division by the sine of the phase advance is built into the weights. The weights are fixed-point constants, worked out when the design is elaborated from the slot count and the number of IF cycles per slot sequence. A slot counter advances only when a sample is accepted. Because of this, gaps in the input strobe do not shift the weights against the sinusoid. Four multipliers form the two dot products. The sums are then rounded to the nearest integer, clamped to the output width and registered. A new vector comes out one clock after each accepted sample, once two samples have been seen.

Top module: `iq_pair_detector`

## Requirements
- R1: While reset is asserted and right after it, `iq_valid` is 0 and `i_out` and `q_out` are 0.
- R2: After reset, `iq_valid` stays 0 until two samples have been accepted, where a sample is accepted in any cycle with `samp_valid` high. The first sample accepted after reset takes weight slot 0.
- R3: Each sample accepted after the first produces exactly one `iq_valid` pulse, in the clock cycle right after it is accepted. `iq_valid` is never high otherwise.
- R4: Let xp be the earlier sample of a pair, xc the later one, and s the slot of xp. With Δ = 2π·IF_CYC/SLOTS and φ = s·Δ, `i_out` is formed from xp·round(2^F·sin(φ+Δ)/sinΔ) + xc·round(−2^F·sinφ/sinΔ), where F = COEF_W−2.
- R5: Using the same pair, `q_out` is formed from xp·round(−2^F·cos(φ+Δ)/sinΔ) + xc·round(2^F·cosφ/sinΔ).
- R6: The weight slot advances only on accepted samples. Idle cycles leave it unchanged, so a sinusoid delivered with gaps still gives a constant vector.
- R7: The slot counts 0, 1, …, SLOTS−1 and then wraps to 0. For an input x_k = round(A·cos(kΔ) + B·sin(kΔ)) that starts at reset, every output stays within 2 LSB of (A, B).
- R8: Each weighted sum S is scaled by floor((S + 2^(F−1)) / 2^F). This is round-to-nearest, with ties going toward positive infinity.
- R9: A scaled result outside the signed OUT_W range is clamped to 2^(OUT_W−1)−1 or −2^(OUT_W−1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| samp_valid | input | 1 | Sample strobe; the sample is accepted when high |
| samp_data | input | DATA_W | Signed ADC sample |
| iq_valid | output | 1 | New I/Q pair present |
| i_out | output | OUT_W | Signed in-phase component |
| q_out | output | OUT_W | Signed quadrature component |

## Verification
Suppose the slot counter slips or advances on an idle cycle. The first vector formed after that uses weights meant for a different phase. The I/Q output then breaks away from the constant tone vector on that same cycle and rotates from slot to slot. A wrong held sample, or a wrong primed flag, shows up one clock after the next accepted sample, as a wrong value or a missing or extra `iq_valid` pulse. Rounding and clamping faults appear at once in the exact comparison made against the bench's integer model. A second, narrower instance forces the clamp to act.

// File: rtl/iq_det_pkg.sv
package iq_det_pkg;

    localparam real PI_R = 3.14159265358979323846;

    // weight selectors: which product a coefficient feeds
    localparam int SEL_PREV_I = 0;
    localparam int SEL_CUR_I  = 1;
    localparam int SEL_PREV_Q = 2;
    localparam int SEL_CUR_Q  = 3;
    localparam int NUM_SEL    = 4;

    function automatic real fold_angle(input real a);
        real r;
        r = a;
        while (r > PI_R)  r = r - 2.0 * PI_R;
        while (r < -PI_R) r = r + 2.0 * PI_R;
        return r;
    endfunction

    function automatic real series_sin(input real a);
        real x;
        real term;
        real acc;
        x    = fold_angle(a);
        term = x;
        acc  = x;
        for (int n = 1; n <= 14; n++) begin
            term = -term * x * x / real'((2 * n) * (2 * n + 1));
            acc  = acc + term;
        end
        return acc;
    endfunction

    function automatic real series_cos(input real a);
        return series_sin(a + PI_R / 2.0);
    endfunction

    // fixed-point weight for one slot and one product, 1/sin(dphi) folded in
    function automatic int weight_int(input int slot, input int slots,
                                      input int if_cyc, input int frac,
                                      input int sel);
        real dphi;
        real phi;
        real sd;
        real v;
        dphi = 2.0 * PI_R * real'(if_cyc) / real'(slots);
        phi  = dphi * real'(slot);
        sd   = series_sin(dphi);
        case (sel)
            SEL_PREV_I: v =  series_sin(phi + dphi) / sd;
            SEL_CUR_I:  v = -series_sin(phi) / sd;
            SEL_PREV_Q: v = -series_cos(phi + dphi) / sd;
            default:    v =  series_cos(phi) / sd;
        endcase
        return int'(v * (2.0 ** frac));
    endfunction

endpackage

// File: rtl/iq_phase_seq.sv
module iq_phase_seq #(
    parameter int SLOTS  = 3,
    parameter int SLOT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    output logic [SLOT_W-1:0] slot
);
    localparam logic [SLOT_W-1:0] LAST = SLOT_W'(SLOTS - 1);

    logic [SLOT_W-1:0] slot_d, slot_q;

    always_comb begin
        slot_d = slot_q;
        if (step) begin
            slot_d = (slot_q == LAST) ? '0 : slot_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) slot_q <= '0;
        else        slot_q <= slot_d;
    end

    assign slot = slot_q;
endmodule

// File: rtl/iq_coef_table.sv
module iq_coef_table #(
    parameter int SLOTS  = 3,
    parameter int SLOT_W = 2,
    parameter int IF_CYC = 2,
    parameter int COEF_W = 18,
    parameter int FRAC   = 16
) (
    input  logic [SLOT_W-1:0]        slot_idx,
    output logic signed [COEF_W-1:0] k_prev_i,
    output logic signed [COEF_W-1:0] k_cur_i,
    output logic signed [COEF_W-1:0] k_prev_q,
    output logic signed [COEF_W-1:0] k_cur_q
);
    import iq_det_pkg::*;

    logic signed [COEF_W-1:0] rom [SLOTS][NUM_SEL];

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        for (genvar c = 0; c < NUM_SEL; c++) begin : g_sel
            localparam int VAL = weight_int(s, SLOTS, IF_CYC, FRAC, c);
            assign rom[s][c] = COEF_W'(VAL);
        end
    end

    always_comb begin
        k_prev_i = '0;
        k_cur_i  = '0;
        k_prev_q = '0;
        k_cur_q  = '0;
        if (32'(slot_idx) < SLOTS) begin
            k_prev_i = rom[slot_idx][SEL_PREV_I];
            k_cur_i  = rom[slot_idx][SEL_CUR_I];
            k_prev_q = rom[slot_idx][SEL_PREV_Q];
            k_cur_q  = rom[slot_idx][SEL_CUR_Q];
        end
    end
endmodule

// File: rtl/iq_dot2.sv
module iq_dot2 #(
    parameter int DATA_W = 16,
    parameter int COEF_W = 18,
    parameter int OUT_W  = 18,
    parameter int FRAC   = 16
) (
    input  logic signed [DATA_W-1:0] xa,
    input  logic signed [DATA_W-1:0] xb,
    input  logic signed [COEF_W-1:0] ka,
    input  logic signed [COEF_W-1:0] kb,
    output logic signed [OUT_W-1:0]  y
);
    localparam int PROD_W = DATA_W + COEF_W;
    localparam int RND_W  = PROD_W + 2;
    localparam logic signed [RND_W-1:0] HALF = RND_W'(1) <<< (FRAC - 1);
    localparam logic signed [RND_W-1:0] MAXV = RND_W'((64'sd1 <<< (OUT_W - 1)) - 64'sd1);
    localparam logic signed [RND_W-1:0] MINV = -MAXV - RND_W'(1);

    logic signed [PROD_W-1:0] prod_a, prod_b;
    logic signed [RND_W-1:0]  acc, scaled;

    assign prod_a = PROD_W'(xa) * PROD_W'(ka);
    assign prod_b = PROD_W'(xb) * PROD_W'(kb);
    assign acc    = RND_W'(prod_a) + RND_W'(prod_b) + HALF;
    assign scaled = acc >>> FRAC;

    always_comb begin
        if (scaled > MAXV)      y = MAXV[OUT_W-1:0];
        else if (scaled < MINV) y = MINV[OUT_W-1:0];
        else                    y = scaled[OUT_W-1:0];
    end
endmodule

// File: rtl/iq_pair_detector.sv
module iq_pair_detector #(
    parameter int DATA_W = 16,
    parameter int COEF_W = 18,
    parameter int OUT_W  = 18,
    parameter int SLOTS  = 3,
    parameter int IF_CYC = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     samp_valid,
    input  logic signed [DATA_W-1:0] samp_data,
    output logic                     iq_valid,
    output logic signed [OUT_W-1:0]  i_out,
    output logic signed [OUT_W-1:0]  q_out
);
    localparam int FRAC   = COEF_W - 2;
    localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;

    typedef struct packed {
        logic signed [DATA_W-1:0] prev_x;
        logic [SLOT_W-1:0]        prev_slot;
        logic                     primed;
        logic                     valid;
        logic signed [OUT_W-1:0]  i;
        logic signed [OUT_W-1:0]  q;
    } state_t;

    state_t st_d, st_q;

    logic [SLOT_W-1:0]        cur_slot;
    logic signed [COEF_W-1:0] k_prev_i, k_cur_i, k_prev_q, k_cur_q;
    logic signed [OUT_W-1:0]  i_res, q_res;

    iq_phase_seq #(.SLOTS(SLOTS), .SLOT_W(SLOT_W)) u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (samp_valid),
        .slot  (cur_slot)
    );

    iq_coef_table #(
        .SLOTS(SLOTS), .SLOT_W(SLOT_W), .IF_CYC(IF_CYC),
        .COEF_W(COEF_W), .FRAC(FRAC)
    ) u_tab (
        .slot_idx (st_q.prev_slot),
        .k_prev_i (k_prev_i),
        .k_cur_i  (k_cur_i),
        .k_prev_q (k_prev_q),
        .k_cur_q  (k_cur_q)
    );

    iq_dot2 #(.DATA_W(DATA_W), .COEF_W(COEF_W), .OUT_W(OUT_W), .FRAC(FRAC)) u_dot_i (
        .xa (st_q.prev_x), .xb (samp_data),
        .ka (k_prev_i),    .kb (k_cur_i),
        .y  (i_res)
    );

    iq_dot2 #(.DATA_W(DATA_W), .COEF_W(COEF_W), .OUT_W(OUT_W), .FRAC(FRAC)) u_dot_q (
        .xa (st_q.prev_x), .xb (samp_data),
        .ka (k_prev_q),    .kb (k_cur_q),
        .y  (q_res)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        if (samp_valid) begin
            st_d.prev_x    = samp_data;
            st_d.prev_slot = cur_slot;
            st_d.primed    = 1'b1;
            if (st_q.primed) begin
                st_d.valid = 1'b1;
                st_d.i     = i_res;
                st_d.q     = q_res;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign iq_valid = st_q.valid;
    assign i_out    = st_q.i;
    assign q_out    = st_q.q;
endmodule

// File: rtl/iq_pair_detector_chk.sv
module iq_pair_detector_chk #(
    parameter int SLOTS  = 3,
    parameter int SLOT_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              samp_valid,
    input logic              iq_valid,
    input logic [SLOT_W-1:0] slot
);
    localparam logic [SLOT_W-1:0] LAST = SLOT_W'(SLOTS - 1);

    logic [1:0] seen_d, seen_q;

    always_comb begin
        seen_d = seen_q;
        if (samp_valid && seen_q != 2'd2) seen_d = seen_q + 2'd1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) seen_q <= '0;
        else        seen_q <= seen_d;
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !iq_valid);

    // R2
    first_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        iq_valid |-> seen_q == 2'd2);

    // R3
    one_per_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (samp_valid && seen_q != 2'd0) |=> iq_valid);

    // R3
    no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
        iq_valid |-> $past(samp_valid));

    // R6
    slot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !samp_valid |=> $stable(slot));

    // R7
    slot_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        32'(slot) < SLOTS);

    // R7
    slot_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (samp_valid && slot == LAST) |=> slot == '0);
endmodule

bind iq_pair_detector iq_pair_detector_chk #(.SLOTS(SLOTS), .SLOT_W(SLOT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .samp_valid (samp_valid),
    .iq_valid   (iq_valid),
    .slot       (cur_slot)
);

// File: tb/iq_pair_detector_bench.sv
`timescale 1ns/1ps
module iq_pair_detector_bench;
    localparam int DW = 16, CW = 18, OW = 18, NW = 16, M = 3, IFC = 2;
    localparam int FR = CW - 2;
    localparam real PI_B = 3.14159265358979323846;

    logic clk = 1'b0, rst_n = 1'b0, samp_valid = 1'b0;
    logic signed [DW-1:0] samp_data = '0;
    logic iq_valid, n_valid;
    logic signed [OW-1:0] i_out, q_out;
    logic signed [NW-1:0] n_i, n_q;

    always #2 clk = ~clk;

    iq_pair_detector #(.DATA_W(DW), .COEF_W(CW), .OUT_W(OW), .SLOTS(M), .IF_CYC(IFC)) u_iq_pair_detector (
        .clk(clk), .rst_n(rst_n), .samp_valid(samp_valid), .samp_data(samp_data),
        .iq_valid(iq_valid), .i_out(i_out), .q_out(q_out));

    iq_pair_detector #(.DATA_W(DW), .COEF_W(CW), .OUT_W(NW), .SLOTS(M), .IF_CYC(IFC)) u_iq_pair_detector_narrow (
        .clk(clk), .rst_n(rst_n), .samp_valid(samp_valid), .samp_data(samp_data),
        .iq_valid(n_valid), .i_out(n_i), .q_out(n_q));

    int checks = 0, errors = 0;
    bit done = 1'b0;

    // bench model state
    bit bm_have;
    int bm_prev, bm_slot_prev, bm_slot;
    bit exp_valid;
    longint e_i, e_q, e_ni, e_nq;
    bit sat_i, sat_q, sat_ni, sat_nq;
    bit tone_on;
    real tone_i, tone_q;
    string tone_tag;

    function automatic int kcoef(int slot, int sel);
        real d, p, v;
        d = 2.0 * PI_B * IFC / M;
        p = d * slot;
        case (sel)
            0: v =  $sin(p + d) / $sin(d);
            1: v = -$sin(p) / $sin(d);
            2: v = -$cos(p + d) / $sin(d);
            default: v = $cos(p) / $sin(d);
        endcase
        return int'(v * (2.0 ** FR));
    endfunction

    function automatic longint scaled(int xp, int xc, int kp, int kc);
        longint s;
        s = longint'(xp) * kp + longint'(xc) * kc;
        return (s + (64'sd1 <<< (FR - 1))) >>> FR;
    endfunction

    function automatic longint clampw(longint v, int w);
        longint hi, lo;
        hi = (64'sd1 <<< (w - 1)) - 1;
        lo = -hi - 1;
        if (v > hi) return hi;
        if (v < lo) return lo;
        return v;
    endfunction

    task automatic check(bit ok, string req, longint act, longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic compare_outputs();
        longint ai, aq;
        check(iq_valid == exp_valid, exp_valid ? "R3" : "R2", iq_valid, exp_valid);
        check(n_valid == exp_valid, exp_valid ? "R3" : "R2", n_valid, exp_valid);
        if (exp_valid && iq_valid) begin
            check(longint'(i_out) == e_i, sat_i ? "R9" : "R4 R8", i_out, e_i);
            check(longint'(q_out) == e_q, sat_q ? "R9" : "R5 R8", q_out, e_q);
            check(longint'(n_i) == e_ni, sat_ni ? "R9" : "R4", n_i, e_ni);
            check(longint'(n_q) == e_nq, sat_nq ? "R9" : "R5", n_q, e_nq);
            if (tone_on) begin
                ai = longint'(i_out) - longint'($rtoi(tone_i + ((tone_i < 0.0) ? -0.5 : 0.5)));
                aq = longint'(q_out) - longint'($rtoi(tone_q + ((tone_q < 0.0) ? -0.5 : 0.5)));
                check(ai >= -2 && ai <= 2, tone_tag, i_out, longint'($rtoi(tone_i)));
                check(aq >= -2 && aq <= 2, tone_tag, q_out, longint'($rtoi(tone_q)));
            end
        end
    endtask

    // one clock: check what the previous drive produced, then drive anew
    task automatic step(bit v, int x);
        longint r;
        @(negedge clk);
        compare_outputs();
        samp_valid = v;
        samp_data  = DW'(x);
        exp_valid  = 1'b0;
        if (v) begin
            if (bm_have) begin
                exp_valid = 1'b1;
                r = scaled(bm_prev, x, kcoef(bm_slot_prev, 0), kcoef(bm_slot_prev, 1));
                e_i = clampw(r, OW);  sat_i = (e_i != r);
                e_ni = clampw(r, NW); sat_ni = (e_ni != r);
                r = scaled(bm_prev, x, kcoef(bm_slot_prev, 2), kcoef(bm_slot_prev, 3));
                e_q = clampw(r, OW);  sat_q = (e_q != r);
                e_nq = clampw(r, NW); sat_nq = (e_nq != r);
            end
            bm_prev      = x;
            bm_slot_prev = bm_slot;
            bm_slot      = (bm_slot + 1) % M;
            bm_have      = 1'b1;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        samp_valid = 1'b0;
        repeat (3) @(negedge clk);
        // R1
        check(iq_valid == 1'b0, "R1", iq_valid, 0);
        check(i_out == '0, "R1", i_out, 0);
        check(q_out == '0, "R1", q_out, 0);
        bm_have = 1'b0; bm_slot = 0; bm_slot_prev = 0;
        exp_valid = 1'b0; tone_on = 1'b0;
        rst_n = 1'b1;
    endtask

    // R6 R7: quantized tone from reset, optional idle gaps
    task automatic run_tone(real a, real b, int n, int gap_pct, string tag);
        real d, xr;
        do_reset();
        tone_i = a; tone_q = b; tone_tag = tag; tone_on = 1'b1;
        d = 2.0 * PI_B * IFC / M;
        for (int k = 0; k < n; k++) begin
            while (gap_pct > 0 && int'($urandom_range(99)) < gap_pct) step(1'b0, 0);
            xr = a * $cos(d * k) + b * $sin(d * k);
            step(1'b1, int'(xr));
        end
        step(1'b0, 0);
        tone_on = 1'b0;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        do_reset();
        // R1 R2: right after reset nothing is valid, first sample gives no output
        step(1'b1, 1234);
        step(1'b0, 0);
        step(1'b1, -777);
        step(1'b0, 0);

        run_tone(20000.0, -9000.0, 60, 0, "R7");
        run_tone(-15000.0, 17000.0, 60, 0, "R7");
        run_tone(3000.5, 22000.0, 80, 40, "R6");
        run_tone(-21000.0, -4000.0, 80, 60, "R6");

        // R9: full-scale runs drive the narrow instance into the clamp
        do_reset();
        for (int k = 0; k < 7; k++) step(1'b1, 32767);
        for (int k = 0; k < 7; k++) step(1'b1, -32768);
        for (int k = 0; k < 6; k++) step(1'b1, (k % 2) ? 32767 : -32768);
        step(1'b0, 0);

        // R4 R5 R8: random samples, random strobe, extremes mixed in
        do_reset();
        for (int k = 0; k < 400; k++) begin
            int sel, x;
            sel = int'($urandom_range(7));
            if (sel == 0)      x = 32767;
            else if (sel == 1) x = -32768;
            else               x = int'($urandom_range(65535)) - 32768;
            step($urandom_range(99) < 70, x);
        end
        // R2: reset mid-stream restarts the pairing
        do_reset();
        step(1'b1, 5000);
        step(1'b1, -5000);
        step(1'b0, 0);
        step(1'b0, 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R3: watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule